// File: doc/BRIEF.md
# Touch Converter Serial Read Controller

This block is the serial master for a resistive-touch analog-to-digital converter that uses four wires: an active-low select, a serial clock, a command line from master to converter, and a data line from converter to master. A command byte accepted on the stream input is shifted out MSB first. The serial clock keeps running at a fixed rate with no stretching. The block then reads the converter's 16-bit big-endian reply and delivers the 12-bit conversion result on a one-cycle strobe. The converter's busy indication is not used. The clock after the last command bit is a dead busy slot, and the master finds every field by counting clocks.

Two framings are offered. In single-shot framing each conversion takes 24 serial clocks: 8 command clocks, then 16 read clocks. Select is then released for at least one serial-clock period. In overlapped framing (`cont_mode` high) the next command byte starts on clock 16 of the current conversion, while the previous result is still being read. Conversions follow each other every 15 clocks and select stays low.

The command input is a valid/ready stream. A command is taken on any cycle where both `cmd_valid` and `cmd_ready` are high. While `cmd_ready` is low the command is held off and has no effect. The result output has no back-pressure, so the consumer must take every `res_valid` pulse.

Top module: `touch_adc_reader`

## Requirements
- R1: While reset is asserted and while idle, `cs_n` is high, `sclk` is low, `cmd_ready` is high and `res_valid` is low. `sclk` never goes high while `cs_n` is high.
- R2: The command byte leaves on `sdo` MSB first, one bit per serial clock, during the first 8 clocks of a conversion. `sdo` changes only on a falling `sclk` edge and is stable while `sclk` is high.
- R3: The bit sampled on the 9th clock of a conversion (the busy slot) is discarded, so the result does not depend on `sdi` in that clock.
- R4: `sdi` is sampled on rising `sclk` edges. The result is the 12 bits sampled on clocks 10 to 21, first bit as MSB, which are bits 14..3 of the returned word. Bits sampled on clocks 22 to 24 are ignored.
- R5: A single-shot conversion keeps `cs_n` low for exactly 24 serial clocks, with the first command bit on the first rising edge. Afterwards `cs_n` stays high for at least 2*HALF_DIV system clocks before it falls again.
- R6: When `cont_mode` is high and a command is offered, the next command's first bit is sampled on clock 16 of the current conversion (15 clocks per conversion) and `cs_n` stays low. A burst of N overlapped conversions lasts 15*(N-1)+24 clocks. Result read windows never overlap.
- R7: `res_valid` is a single-cycle pulse, issued once per conversion in command order, while `cs_n` is low.
- R8: `cmd_ready` is high only when idle, or in overlapped framing on the falling edge that ends clock 15. A command held valid at other times is not taken and does not alter the frame in progress.
- R9: Each high phase of `sclk` lasts HALF_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_data | input | CMD_W | Command byte to send |
| cont_mode | input | 1 | Select overlapped 15-clock framing |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | RES_W | Conversion result |
| cs_n | output | 1 | Converter select, active low |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Command line to converter |
| sdi | input | 1 | Data line from converter |

## Verification
The assertions assume that the converter changes `sdi` only while `sclk` is low. They also assume that `cmd_valid`, once raised, is held until accepted, and that `cont_mode` changes only while idle. The bench converter model drives `sdi` from the falling edge it observes. The stimulus holds each command until its handshake and toggles `cont_mode` only after the block has drained. Single-shot conversions sweep the 12-bit result space with walking ones and zeros, both extremes and scattered values, and feed a one into the busy slot and the padding. A 12-conversion overlapped burst follows.

// File: rtl/tar_pkg.sv
package tar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } tar_state_e;
endpackage

// File: rtl/tar_sclk_gen.sv
module tar_sclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == CW'(HALF_DIV - 1));
  assign rise = run && tick && !sclk;
  assign fall = run && tick && sclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tar_cmd_shifter.sv
module tar_cmd_shifter #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CMD_W-1:0] din,
  input  logic             shift,
  output logic             sdo
);
  logic [CMD_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)      sr <= '0;
    else if (load)   sr <= din;
    else if (shift)  sr <= {sr[CMD_W-2:0], 1'b0};
  end

  assign sdo = sr[CMD_W-1];
endmodule

// File: rtl/tar_rsp_capture.sv
module tar_rsp_capture #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             rise,
  input  logic             sdi,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data
);
  localparam int NW = $clog2(RES_W + 1);

  logic [RES_W-1:0] sr;
  logic [NW-1:0]    cnt;
  logic             active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr        <= '0;
      cnt       <= '0;
      active    <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      if (arm) begin
        // busy-slot sample is dropped here
        active <= 1'b1;
        cnt    <= '0;
      end else if (rise && active) begin
        sr  <= {sr[RES_W-2:0], sdi};
        cnt <= cnt + 1'b1;
        if (cnt == NW'(RES_W - 1)) begin
          active    <= 1'b0;
          res_valid <= 1'b1;
          res_data  <= {sr[RES_W-2:0], sdi};
        end
      end
    end
  end

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // windows of successive reads never overlap
  assert_no_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> !active);
endmodule

// File: rtl/touch_adc_reader.sv
module touch_adc_reader #(
  parameter int CMD_W    = 8,
  parameter int RES_W    = 12,
  parameter int HALF_DIV = 2,
  parameter int OVL_CLKS = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             cont_mode,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic             cs_n,
  output logic             sclk,
  output logic             sdo,
  input  logic             sdi
);
  import tar_pkg::*;

  localparam int WORD_W     = RES_W + 4;
  localparam int FRAME_LAST = CMD_W + WORD_W - 1;
  localparam int OVL_LAST   = OVL_CLKS - 1;
  localparam int PW         = $clog2(CMD_W + WORD_W);
  localparam int GAP_CYC    = 2 * HALF_DIV;
  localparam int GCW        = $clog2(GAP_CYC) + 1;
  localparam int HCW        = $clog2(GAP_CYC + 2) + 1;

  tar_state_e     state;
  logic [PW-1:0]  pos;
  logic [GCW-1:0] gap_cnt;
  logic           run, rise, fall, at_handoff, load, arm;
  logic [HCW-1:0] cs_hi_cnt;

  assign run        = (state == ST_RUN);
  assign cs_n       = !run;
  assign at_handoff = run && fall && cont_mode && (pos == PW'(OVL_LAST));
  assign cmd_ready  = (state == ST_IDLE) || at_handoff;
  assign load       = cmd_valid && cmd_ready;
  assign arm        = rise && (pos == PW'(CMD_W));

  tar_sclk_gen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sclk(sclk), .rise(rise), .fall(fall)
  );

  tar_cmd_shifter #(.CMD_W(CMD_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .load(load), .din(cmd_data),
    .shift(fall), .sdo(sdo)
  );

  tar_rsp_capture #(.RES_W(RES_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .arm(arm), .rise(rise), .sdi(sdi),
    .res_valid(res_valid), .res_data(res_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pos     <= '0;
      gap_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_valid) begin
          state <= ST_RUN;
          pos   <= '0;
        end
        ST_RUN: if (fall) begin
          if (load) begin
            pos <= '0;
          end else if (pos == PW'(FRAME_LAST)) begin
            state   <= ST_GAP;
            gap_cnt <= '0;
          end else begin
            pos <= pos + 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_cnt == GCW'(GAP_CYC - 1)) state <= ST_IDLE;
          else gap_cnt <= gap_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // high-time counter of select, saturating, used to guard the idle gap
  always_ff @(posedge clk) begin
    if (!rst_n)                         cs_hi_cnt <= HCW'(GAP_CYC);
    else if (!cs_n)                     cs_hi_cnt <= '0;
    else if (cs_hi_cnt < HCW'(GAP_CYC)) cs_hi_cnt <= cs_hi_cnt + 1'b1;
  end

  assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_sdo_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk && $past(sclk)) |-> $stable(sdo));

  assert_cs_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (cs_hi_cnt >= HCW'(GAP_CYC)));

  assert_valid_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !cs_n);
endmodule

// File: tb/touch_adc_reader_tb.sv
module touch_adc_reader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int GAP        = 2 * HALF;

  logic clk = 1'b0;
  logic rst_n, cmd_valid, cmd_ready, cont_mode, res_valid;
  logic [7:0]  cmd_data;
  logic [11:0] res_data;
  logic cs_n, sclk, sdo, sdi;

  always #(CLK_PERIOD/2) clk = ~clk;

  touch_adc_reader #(.HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cont_mode(cont_mode), .res_valid(res_valid),
    .res_data(res_data), .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .sdi(sdi)
  );

  int checks = 0, fails = 0;
  int n_tx = 0, n_rx = 0, n_got = 0;
  logic [7:0]  tx_cmd [64];
  logic [7:0]  rx_cmd [64];
  logic [11:0] res_tab [64];
  logic        busy_tab [64];
  logic        pad_tab [64];
  int          start_rise [64];
  int          frame_of [64];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model and port monitors, evaluated away from the active edge
  bit prev_sclk = 0, prev_cs = 1, prev_sdo = 0, prev_valid = 0;
  bit listening = 1, pend = 0, act = 0;
  int rises = 0, cbits = 0, oidx = 0, cur = 0, hi_len = 0;
  int gap = 1000, frames = 0, convs = 0, sdo_moves = 0, idle_clk = 0, dbl_valid = 0;
  logic [7:0] csh = 0;

  initial sdi = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && prev_cs) begin
        if (frames > 0) chk(gap >= GAP, "R5 select high gap", gap, GAP);
        frames++; rises = 0; convs = 0;
      end
      if (cs_n) gap++; else gap = 0;
      if (cs_n && !prev_cs) begin
        chk(rises == 15*(convs-1) + 24, (convs > 1) ? "R6 burst clocks" : "R5 frame clocks",
            rises, 15*(convs-1) + 24);
        act = 0; pend = 0; listening = 1; sdi = 1'b0;
      end
      if (cs_n && sclk) idle_clk++;
      if (sclk && prev_sclk && sdo !== prev_sdo) sdo_moves++;
      if (sclk && !prev_sclk && !cs_n) begin
        rises++; hi_len = 1;
        if (listening) begin
          if (sdo) begin
            listening = 0; csh = 8'h01; cbits = 1;
            start_rise[n_rx] = rises; frame_of[n_rx] = frames;
          end
        end else begin
          csh = {csh[6:0], sdo}; cbits++;
          if (cbits == 8) begin
            rx_cmd[n_rx] = csh; cur = n_rx; n_rx++; convs++;
            listening = 1; pend = 1;
          end
        end
      end else if (sclk) hi_len++;
      if (!sclk && prev_sclk) begin
        chk(hi_len == HALF, "R9 sclk high phase", hi_len, HALF);
        if (pend) begin act = 1; oidx = 0; pend = 0; end
        if (act) begin
          if (oidx == 0)       sdi = busy_tab[cur];
          else if (oidx <= 12) sdi = res_tab[cur][12-oidx];
          else                 sdi = pad_tab[cur];
          oidx++;
        end
      end
      if (res_valid) begin
        chk(res_data == res_tab[n_got],
            (busy_tab[n_got] || pad_tab[n_got]) ? "R3 result with busy/pad ones" : "R4 result",
            res_data, res_tab[n_got]);
        n_got++;
      end
      if (res_valid && prev_valid) dbl_valid++;
    end
    prev_sclk = sclk; prev_cs = cs_n; prev_sdo = sdo; prev_valid = res_valid;
  end

  task automatic send(input logic [7:0] c, input logic [11:0] r, input bit b, input bit p);
    bit h;
    tx_cmd[n_tx] = c; res_tab[n_tx] = r; busy_tab[n_tx] = b; pad_tab[n_tx] = p;
    n_tx++;
    cmd_valid = 1'b1; cmd_data = c;
    forever begin
      h = cmd_ready;
      @(negedge clk);
      if (h) break;
    end
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 3000; k++) begin
      if (n_got == n_tx && cs_n && cmd_ready) break;
      @(negedge clk);
    end
  endtask

  bit finished = 0;

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [11:0] v;
    int first_burst;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = 8'h00; cont_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1,      "R1 reset cs_n",      cs_n, 1);
    chk(sclk == 1'b0,      "R1 reset sclk",      sclk, 0);
    chk(cmd_ready == 1'b1, "R1 reset cmd_ready", cmd_ready, 1);
    chk(res_valid == 1'b0, "R1 reset res_valid", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1 && cmd_ready == 1'b1, "R1 idle after reset", cs_n, 1);

    // single-shot sweep; each next command is held valid through the frame (R8)
    for (int i = 0; i < 32; i++) begin
      if (i < 12)       v = 12'(1 << i);
      else if (i < 24)  v = ~12'(1 << (i - 12));
      else if (i == 24) v = 12'h000;
      else if (i == 25) v = 12'hFFF;
      else              v = 12'((i * 701) & 12'hFFF);
      send(8'h80 | 8'(i), v, i[0], i[1]);
    end
    wait_done();

    // overlapped burst, R6
    cont_mode = 1'b1;
    first_burst = n_tx;
    for (int j = 0; j < 12; j++)
      send(8'hC0 | 8'(j), 12'((j * 1237 + 5) & 12'hFFF), j[0], 1'b1);
    wait_done();
    chk(frame_of[first_burst] == frame_of[n_tx-1], "R6 select held low across burst",
        frame_of[n_tx-1] - frame_of[first_burst], 0);

    // lone command in overlapped framing drains as a full frame
    send(8'hA5, 12'hA5C, 1'b1, 1'b0);
    wait_done();
    cont_mode = 1'b0;
    repeat (10) @(negedge clk);

    chk(n_got == n_tx, "R7 one result per conversion", n_got, n_tx);
    chk(n_rx == n_tx, "R2 commands received", n_rx, n_tx);
    for (int i = 0; i < n_tx; i++) begin
      chk(rx_cmd[i] == tx_cmd[i], "R2 command bits", rx_cmd[i], tx_cmd[i]);
      if (i > 0 && frame_of[i] == frame_of[i-1])
        chk(start_rise[i] - start_rise[i-1] == 15, "R6 command spacing",
            start_rise[i] - start_rise[i-1], 15);
      else
        chk(start_rise[i] == 1, "R5 R8 command on first clock", start_rise[i], 1);
    end
    chk(sdo_moves == 0, "R2 sdo moved while sclk high", sdo_moves, 0);
    chk(idle_clk == 0,  "R1 sclk high with cs_n high", idle_clk, 0);
    chk(dbl_valid == 0, "R7 res_valid wider than one cycle", dbl_valid, 0);
    finish_run();
  end
endmodule